// File: doc/BRIEF.md
# Two-Tier Weighted Slave Port Arbiter

This block sits in front of one slave port of a multi-master bus matrix and decides which master owns that port. Masters come in two tiers. The low-numbered masters form a fixed-priority tier. The rest share the port by weighted round robin, and each has its own quota of consecutive transfers. A fixed-tier request is served before any weighted master whenever the arbiter re-arbitrates. A weighted master that is inside its quota is not cut short by the fixed tier, except through a bounded-latency timer. When a fixed-tier master has waited the programmed number of cycles, the timer forces the weighted owner off the port.

The grant is registered. It moves only on a transfer boundary, which is a cycle with `xfer_ready` high. A transfer of the current owner completes on a cycle with both `xfer_valid` and `xfer_ready` high, and only completed transfers use up quota. Weight and latency settings are plain level inputs that may change at any time. There is no data path here, so no port uses a valid/ready handshake. `xfer_valid` and `xfer_ready` are observation strobes of the owner's address phase and carry no back-pressure from this block.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset `grant` is all zeros. At all times `grant` is zero or one-hot, and when it is non-zero `grant_idx` is the index of its set bit.
- R2: `grant` and `grant_idx` change only on the clock edge that ends a cycle with `xfer_ready` high.
- R3: Masters 0 to N_FIX-1 are the fixed tier. At re-arbitration, the lowest-indexed requesting fixed master wins. A fixed owner is re-arbitrated at every boundary.
- R4: Weighted masters N_FIX+j are granted only when no fixed request is present at re-arbitration. The winner is the first requesting weighted master after the last weighted owner, wrapping around. Out of reset the search starts at j=0.
- R5: The weight of weighted master j is `weight_cfg[5*j+4:5*j]`, and field value w allows w+1 completed transfers (0 means 1, 31 means 32). When the quota is used up, the arbiter re-arbitrates at that boundary. If the same master wins again, it gets a fresh quota.
- R6: While a weighted owner is within its quota and still requesting, fixed requests do not take the port until the latency limit expires.
- R7: When LAT_LIMIT is set and `lat_cfg` is L (L+1 cycles), a fixed request held for L+1 consecutive cycles while a weighted master owns the port makes the grant move to the lowest requesting fixed master at the first boundary that ends such a cycle.
- R8: The latency timer runs only on fixed-tier requests. Weighted masters that are waiting never shorten a weighted owner's quota.
- R9: A weighted owner that drops its request loses the port at the next boundary.
- R10: With no request present, the grant stays parked on the last owner. A change of grant always goes to a master that was requesting in the cycle before.
- R11: A change to a weight takes effect at that master's next quota load, and a change to `lat_cfg` takes effect at once, with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_FIX+N_WRR | Request line of each master, fixed tier in the low bits |
| xfer_valid | input | 1 | Owner presents a transfer in this cycle |
| xfer_ready | input | 1 | Transfer boundary: the owner's address phase completes |
| weight_cfg | input | 5*N_WRR | Weight field per weighted master, encoded as count minus one |
| lat_cfg | input | 3 | Latency limit for the fixed tier, encoded as cycles minus one |
| grant | output | N_FIX+N_WRR | One-hot grant, zero only before the first grant |
| grant_idx | output | clog2(N_FIX+N_WRR) | Index of the granted master |

## Verification
Assertions check on every cycle the properties that hold edge by edge. The grant is one-hot and stays frozen while `xfer_ready` is low. The fixed tier beats a fixed or idle owner. An expired latency timer removes the weighted owner. Every change of grant is backed by a request. The things that span many cycles can only be shown by the bench scenarios, because they depend on run lengths and history: exact quota counts per weight, the rotation order, the exact cycle of latency preemption, parking, and settings changed mid-quota. The bench's reference model follows them cycle by cycle under directed and random traffic.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int WGT_W = 5;
  localparam int LAT_W = 3;

  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_FIX  = 2'd1,
    TIER_WRR  = 2'd2
  } tier_e;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int N_REQ = 2,
  parameter int IDX_W = 3
) (
  input  logic [N_REQ-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_REQ = 3,
  parameter int PW    = 2
) (
  input  logic [N_REQ-1:0] req,
  input  logic [PW-1:0]    last,
  output logic             found,
  output logic [PW-1:0]    idx
);
  int pos;
  always_comb begin
    found = 1'b0;
    idx   = last;
    pos   = 0;
    for (int k = N_REQ; k >= 1; k--) begin
      pos = int'(last) + k;
      if (pos >= N_REQ) pos = pos - N_REQ;
      if (req[pos[PW-1:0]]) begin
        found = 1'b1;
        idx   = pos[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_lat_timer.sv
module arb_lat_timer #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LAT_W-1:0] lat_cfg,
  output logic             expired
);
  logic [LAT_W-1:0] waited;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               waited <= '0;
    else if (!run)            waited <= '0;
    else if (waited != '1)    waited <= waited + 1'b1;
  end

  assign expired = run && (waited >= lat_cfg);

  // R7: once expired, the condition stays expired while the wait continues
  a_r7_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && run && $stable(lat_cfg)) |=> (!run || expired));
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
  import arb_pkg::*;
#(
  parameter int N_FIX     = 2,
  parameter int N_WRR     = 3,
  parameter bit LAT_LIMIT = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_FIX+N_WRR-1:0]        req,
  input  logic                          xfer_valid,
  input  logic                          xfer_ready,
  input  logic [N_WRR*arb_pkg::WGT_W-1:0] weight_cfg,
  input  logic [arb_pkg::LAT_W-1:0]     lat_cfg,
  output logic [N_FIX+N_WRR-1:0]        grant,
  output logic [$clog2(N_FIX+N_WRR)-1:0] grant_idx
);
  localparam int N_MST = N_FIX + N_WRR;
  localparam int IW    = $clog2(N_MST);
  localparam int PW    = (N_WRR > 1) ? $clog2(N_WRR) : 1;
  localparam int QW    = WGT_W + 1;

  logic [IW-1:0] own_idx, n_idx;
  logic          own_vld, n_vld;
  logic [PW-1:0] wptr, n_ptr;
  logic [QW-1:0] qcnt, n_q;

  logic             fix_any, rr_found, lat_exp, lat_run, hold;
  logic [IW-1:0]    fix_idx, own_off;
  logic [PW-1:0]    rr_idx, own_w;
  logic [WGT_W-1:0] w_rr, w_own;
  tier_e            tier;

  arb_fixed_pick #(.N_REQ(N_FIX), .IDX_W(IW)) u_fix (
    .req(req[N_FIX-1:0]), .found(fix_any), .idx(fix_idx));

  arb_rr_pick #(.N_REQ(N_WRR), .PW(PW)) u_rr (
    .req(req[N_MST-1:N_FIX]), .last(wptr), .found(rr_found), .idx(rr_idx));

  always_comb begin
    if (!own_vld)              tier = TIER_NONE;
    else if (own_idx < IW'(N_FIX)) tier = TIER_FIX;
    else                       tier = TIER_WRR;
  end

  assign own_off = own_idx - IW'(N_FIX);
  assign own_w   = own_off[PW-1:0];
  assign w_rr    = weight_cfg[int'(rr_idx)*WGT_W +: WGT_W];
  assign w_own   = weight_cfg[int'(own_w)*WGT_W +: WGT_W];
  assign lat_run = LAT_LIMIT && (tier == TIER_WRR) && fix_any;

  arb_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .run(lat_run), .lat_cfg(lat_cfg), .expired(lat_exp));

  assign hold = (tier == TIER_WRR) && req[own_idx] &&
                !(xfer_valid && qcnt == QW'(1)) && !lat_exp;

  always_comb begin
    n_idx = own_idx;
    n_vld = own_vld;
    n_ptr = wptr;
    n_q   = qcnt;
    if (xfer_ready) begin
      if (hold) begin
        if (xfer_valid) n_q = qcnt - 1'b1;
      end else if (fix_any) begin
        n_vld = 1'b1;
        n_idx = fix_idx;
      end else if (rr_found) begin
        n_vld = 1'b1;
        n_idx = IW'(N_FIX) + IW'(rr_idx);
        n_ptr = rr_idx;
        n_q   = {1'b0, w_rr} + 1'b1;
      end else if (tier == TIER_WRR) begin
        n_q   = {1'b0, w_own} + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_idx <= '0;
      own_vld <= 1'b0;
      wptr    <= PW'(N_WRR - 1);
      qcnt    <= QW'(1);
    end else begin
      own_idx <= n_idx;
      own_vld <= n_vld;
      wptr    <= n_ptr;
      qcnt    <= n_q;
    end
  end

  assign grant     = own_vld ? (N_MST'(1) << own_idx) : '0;
  assign grant_idx = own_idx;

  // R1: grant never has more than one bit set
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: no movement without a transfer boundary
  a_r2_frozen_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_ready |=> $stable(grant));

  // R3: fixed tier beats an idle or fixed owner
  a_r3_fixed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ready && fix_any && tier != TIER_WRR) |=> (grant[N_MST-1:N_FIX] == '0 && grant != '0));

  // R7: expired latency limit removes the weighted owner
  a_r7_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ready && lat_exp) |=> (grant[N_MST-1:N_FIX] == '0));

  // R10: every grant change lands on a master that was requesting
  a_r10_backed_by_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != $past(grant)) |-> (|($past(req) & grant)));
endmodule

// File: tb/test_slave_port_arbiter.sv
module test_slave_port_arbiter;
  localparam int CLK_P = 10;
  localparam int NF = 2;
  localparam int NW = 3;
  localparam int N  = NF + NW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0;
  logic           xv = 1'b0;
  logic           xr = 1'b0;
  logic [NW*5-1:0] wcfg = '0;
  logic [2:0]     lcfg = 3'd7;
  logic [N-1:0]   grant;
  logic [2:0]     gidx;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1 reset";

  int m_own = -1, m_q = 1, m_ptr = NW - 1, m_lat = 0;
  int lowf, hit;
  bit fany, wown, run, expd;

  always #(CLK_P/2) clk = ~clk;

  slave_port_arbiter i_slave_port_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_valid(xv), .xfer_ready(xr),
    .weight_cfg(wcfg), .lat_cfg(lcfg), .grant(grant), .grant_idx(gidx));

  function automatic int wget(int j);
    return int'((wcfg >> (5*j)) & 15'h1f);
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = -1; m_q = 1; m_ptr = NW - 1; m_lat = 0;
    end else begin
      fany = 1'b0; lowf = -1;
      for (int i = NF - 1; i >= 0; i--) if (req[i]) begin fany = 1'b1; lowf = i; end
      wown = (m_own >= NF);
      run  = wown && fany;
      expd = run && (m_lat >= int'(lcfg));
      m_lat = run ? ((m_lat < 7) ? m_lat + 1 : 7) : 0;
      if (xr) begin
        if (wown && req[m_own] && !(xv && m_q == 1) && !expd) begin
          if (xv) m_q--;
        end else if (fany) begin
          m_own = lowf;
        end else begin
          hit = -1;
          for (int k = NW; k >= 1; k--) if (req[NF + ((m_ptr + k) % NW)]) hit = (m_ptr + k) % NW;
          if (hit >= 0) begin
            m_own = NF + hit; m_ptr = hit; m_q = wget(hit) + 1;
          end else if (wown) begin
            m_q = wget(m_own - NF) + 1;
          end
        end
      end
    end
  end

  task automatic compare();
    logic [N-1:0] eg;
    eg = (m_own < 0) ? '0 : (N'(1) << m_own);
    n_cmp++;
    if (grant !== eg || (m_own >= 0 && int'(gidx) != m_own)) begin
      n_bad++;
      $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d", tag, grant, gidx, eg, m_own);
    end
  endtask

  task automatic tick(int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic direct(string t, logic [N-1:0] got, logic [N-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected %b", t, got, exp);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    direct("R1 reset state", grant, '0);
    rst_n = 1'b1;
    xr = 1'b1; xv = 1'b1;
    tick(3);
    direct("R1 no grant without request", grant, '0);

    tag = "R4 R5 rotation and quota";
    wcfg = {5'd1, 5'd2, 5'd0};
    req = 5'b11100;
    tick(30);

    tag = "R2 stalled boundaries";
    for (int c = 0; c < 60; c++) begin
      xr = ($urandom % 2) == 1;
      xv = ($urandom % 3) != 0;
      tick(1);
    end
    xr = 1'b1; xv = 1'b1;

    tag = "R6 R3 quota beats fixed, lowest fixed wins";
    lcfg = 3'd7;
    wcfg = {5'd2, 5'd2, 5'd2};
    req = 5'b11100;
    tick(2);
    req = 5'b11111;
    tick(12);
    req = 5'b11110;
    tick(8);

    tag = "R9 owner drops request";
    req = 5'b01000;
    tick(3);
    req = 5'b10000;
    tick(3);

    tag = "R10 parking";
    req = '0;
    tick(5);
    direct("R10 parked on last owner", grant, 5'b10000);
    req = 5'b00010;
    tick(2);
    req = '0;
    tick(4);
    direct("R10 parked on fixed owner", grant, 5'b00010);

    tag = "R7 latency preemption";
    wcfg = {5'd31, 5'd31, 5'd31};
    lcfg = 3'd2;
    req = 5'b10000;
    tick(3);
    req = 5'b10001;
    tick(2);
    direct("R7 weighted still holds before limit", grant, 5'b10000);
    tick(1);
    direct("R7 fixed granted after three cycles", grant, 5'b00001);

    tag = "R8 weighted waiters do not preempt";
    lcfg = 3'd0;
    wcfg = {5'd5, 5'd5, 5'd5};
    req = 5'b11100;
    tick(25);

    tag = "R11 runtime setting changes";
    wcfg = {5'd0, 5'd3, 5'd7};
    tick(10);
    wcfg = {5'd2, 5'd0, 5'd1};
    tick(10);
    req = 5'b11101;
    lcfg = 3'd5;
    tick(4);
    lcfg = 3'd1;
    tick(6);

    tag = "random R2 R3 R4 R5 R6 R7 R9 R10";
    for (int c = 0; c < 3000; c++) begin
      if (c % 400 == 0) begin
        wcfg = 15'($urandom);
        lcfg = 3'($urandom);
      end
      if ($urandom % 4 == 0) req = N'($urandom) & ((c % 7 == 0) ? 5'b11100 : 5'b11111);
      xr = ($urandom % 4) != 0;
      xv = ($urandom % 5) != 0;
      tick(1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule